// File: doc/BRIEF.md
# Add/Subtract Condition Evaluator

This block adds or subtracts two words and, in the same pass, decides whether a 4-bit condition on that result holds. A pipeline uses the condition bit to cancel the instruction that follows. Subtraction is carried out as `a + ~b + 1`. The unit produces the result word, the carry out of the top bit, a signed-overflow flag and the condition bit. All four are registered and appear one clock after the operation is presented.

The condition field has two parts. The upper three bits pick one of eight base tests. The lowest bit inverts the picked test. The signed "less than" and "less or equal" tests use N XOR V rather than the sign bit alone, so they stay correct when the arithmetic overflows. The unsigned "less or equal" style test is formed as no-carry OR zero. The set also holds a never/always pair, an overflow test and an odd test. When no operation is presented, the registered outputs keep their last values. Word width is a parameter.

Top module: `addsub_cond_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `res`, `carry`, `ovf` and `cond_true` are all 0.
- R2: `out_valid` equals the value `op_valid` had at the previous rising clock edge.
- R3: For an addition (`op_sub`=0) accepted at edge k, after edge k `{carry,res}` equals the (WIDTH+1)-bit unsigned sum of `a` and `b`.
- R4: For a subtraction (`op_sub`=1), `res` equals `a - b` modulo 2^WIDTH and `carry` is 1 exactly when `a >= b` unsigned (no borrow).
- R5: `ovf` is 1 exactly when the true signed result of the operation lies outside the signed WIDTH-bit range.
- R6: The selector is `cond[3:1]` and the invert bit is `cond[0]`; `cond_true` = base test XOR `cond[0]`. Selector 0 is "never", so code 0 gives 0 and code 1 gives 1.
- R7: Selector 1 tests `res == 0`, and selector 7 tests `res[0] == 1` (odd).
- R8: Selector 2 tests N XOR V, where N is `res[WIDTH-1]` and V is the overflow flag. Selector 3 tests (N XOR V) OR Z, where Z means `res == 0`. These match the true signed result being below zero and not above zero.
- R9: Selector 4 tests `carry == 0`; selector 5 tests `carry == 0` OR `res == 0`.
- R10: Selector 6 tests the signed-overflow flag.
- R11: In a cycle where `op_valid` is 0, `res`, `carry`, `ovf` and `cond_true` keep their values across the next edge, whatever `a`, `b`, `op_sub` and `cond` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sub | input | 1 | 1 = subtract `b` from `a`, 0 = add |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cond | input | 4 | Condition code: selector in [3:1], invert in [0] |
| out_valid | output | 1 | Registered outputs hold a fresh result |
| res | output | WIDTH | Registered result word |
| carry | output | 1 | Registered carry out of the top bit (1 = no borrow on subtract) |
| ovf | output | 1 | Registered signed-overflow flag |
| cond_true | output | 1 | Registered condition outcome |

## Verification
The bench builds the unit at the default width of 32. Its reference model uses 64-bit signed integers, so the true signed sum or difference is always available. The model can therefore state the signed tests directly as "result below zero" and "result not above zero", and needs no N and V flags. The operands are the full cross product of 0, 1, -1, the most positive value and the most negative value, under both operations and all sixteen condition codes. This set reaches every overflow direction, the wrap to zero at the most negative value, and the carry/borrow edges. Random operands and idle cycles with changing inputs follow.

// File: rtl/addsub_cond_pkg.sv
package addsub_cond_pkg;

    typedef enum logic [2:0] {
        SEL_NEVER      = 3'd0,
        SEL_ZERO       = 3'd1,
        SEL_SLT        = 3'd2,
        SEL_SLE        = 3'd3,
        SEL_NOCARRY    = 3'd4,
        SEL_NOCARRY_EQ = 3'd5,
        SEL_OVF        = 3'd6,
        SEL_ODD        = 3'd7
    } cond_sel_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic cout;
        logic ovf;
        logic odd;
    } alu_flags_t;

    localparam int unsigned COND_W = 4;

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             op_sub,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output addsub_cond_pkg::alu_flags_t flags
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = op_sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, op_sub};
        sum   = wide[WIDTH-1:0];

        flags.cout = wide[WIDTH];
        flags.neg  = wide[MSB];
        flags.zero = ~|wide[WIDTH-1:0];
        flags.odd  = wide[0];
        flags.ovf  = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
    end
endmodule

// File: rtl/cond_select.sv
module cond_select (
    input  logic [addsub_cond_pkg::COND_W-1:0] cond,
    input  addsub_cond_pkg::alu_flags_t        flags,
    output logic                               taken
);
    import addsub_cond_pkg::*;

    cond_sel_e sel;
    logic      base;
    logic      lt_s;

    always_comb begin
        sel  = cond_sel_e'(cond[COND_W-1:1]);
        lt_s = flags.neg ^ flags.ovf;
        unique case (sel)
            SEL_NEVER:      base = 1'b0;
            SEL_ZERO:       base = flags.zero;
            SEL_SLT:        base = lt_s;
            SEL_SLE:        base = lt_s | flags.zero;
            SEL_NOCARRY:    base = ~flags.cout;
            SEL_NOCARRY_EQ: base = ~flags.cout | flags.zero;
            SEL_OVF:        base = flags.ovf;
            SEL_ODD:        base = flags.odd;
            default:        base = 1'b0;
        endcase
        taken = base ^ cond[0];
    end
endmodule

// File: rtl/addsub_cond_unit.sv
module addsub_cond_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       cond,
    output logic             out_valid,
    output logic [WIDTH-1:0] res,
    output logic             carry,
    output logic             ovf,
    output logic             cond_true
);
    import addsub_cond_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] res;
        logic             carry;
        logic             ovf;
        logic             taken;
    } stage_t;

    localparam stage_t STAGE_RST = '0;

    logic [WIDTH-1:0] sum_w;
    alu_flags_t       flags_w;
    logic             taken_w;
    stage_t           st_d;
    stage_t           st_q;

    addsub_core #(.WIDTH(WIDTH)) u_core (
        .op_sub (op_sub),
        .a      (a),
        .b      (b),
        .sum    (sum_w),
        .flags  (flags_w)
    );

    cond_select u_cond (
        .cond  (cond),
        .flags (flags_w),
        .taken (taken_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid;
        if (op_valid) begin
            st_d.res   = sum_w;
            st_d.carry = flags_w.cout;
            st_d.ovf   = flags_w.ovf;
            st_d.taken = taken_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STAGE_RST;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign res       = st_q.res;
    assign carry     = st_q.carry;
    assign ovf       = st_q.ovf;
    assign cond_true = st_q.taken;
endmodule

// File: rtl/addsub_cond_unit_chk.sv
module addsub_cond_unit_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_sub,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [3:0]       cond,
    input logic             out_valid,
    input logic [WIDTH-1:0] res,
    input logic             carry,
    input logic             ovf,
    input logic             cond_true
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (!out_valid && !carry && !ovf && !cond_true && res == '0);
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(op_valid));

    // R3
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_sub |=> {carry, res} == ({1'b0, $past(a)} + {1'b0, $past(b)}));

    // R4
    sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sub |=> res == ($past(a) - $past(b)) && carry == ($past(a) >= $past(b)));

    // R5
    add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_sub |=>
            ovf == (($past(a[WIDTH-1]) == $past(b[WIDTH-1])) && (res[WIDTH-1] != $past(a[WIDTH-1]))));

    // R6
    never_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond[3:1] == 3'd0 |=> cond_true == $past(cond[0]));

    // R7
    zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond[3:1] == 3'd1 |=> cond_true == ((res == '0) ^ $past(cond[0])));

    // R7
    odd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond[3:1] == 3'd7 |=> cond_true == (res[0] ^ $past(cond[0])));

    // R8
    slt_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond[3:1] == 3'd2 |=> cond_true == ((res[WIDTH-1] ^ ovf) ^ $past(cond[0])));

    // R9
    nocarry_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond[3:1] == 3'd4 |=> cond_true == (!carry ^ $past(cond[0])));

    // R10
    ovf_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond[3:1] == 3'd6 |=> cond_true == (ovf ^ $past(cond[0])));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res) && $stable(carry) && $stable(ovf) && $stable(cond_true));
endmodule

bind addsub_cond_unit addsub_cond_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sub    (op_sub),
    .a         (a),
    .b         (b),
    .cond      (cond),
    .out_valid (out_valid),
    .res       (res),
    .carry     (carry),
    .ovf       (ovf),
    .cond_true (cond_true)
);

// File: tb/addsub_cond_unit_tb.sv
`timescale 1ns/1ps
module addsub_cond_unit_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   cond = '0;
    logic         out_valid, carry, ovf, cond_true;
    logic [W-1:0] res;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    logic         e_valid = 1'b0, e_carry = 1'b0, e_ovf = 1'b0, e_ct = 1'b0;
    logic [W-1:0] e_res = '0;
    string        e_ctag = "R6";

    always #2.5 clk = ~clk;

    addsub_cond_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .a(a), .b(b), .cond(cond), .out_valid(out_valid), .res(res),
        .carry(carry), .ovf(ovf), .cond_true(cond_true)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string ptag);
        check("R2", "out_valid", longint'(out_valid), longint'(e_valid));
        check(ptag, "res", longint'(res), longint'(e_res));
        check(ptag, "carry", longint'(carry), longint'(e_carry));
        check(ptag == "R11" ? "R11" : "R5", "ovf", longint'(ovf), longint'(e_ovf));
        check(ptag == "R11" ? "R11" : e_ctag, "cond_true", longint'(cond_true), longint'(e_ct));
    endtask

    // Behavioural model: true signed result from 64-bit integers.
    task automatic model(input logic v, input logic s, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic [3:0] c);
        longint sx, sy, tr;
        logic [W:0] wide;
        logic base, z;
        e_valid = v;
        if (!v) return;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        if (s) begin
            tr      = sx - sy;
            e_res   = x - y;
            e_carry = (x >= y);
        end else begin
            tr      = sx + sy;
            wide    = {1'b0, x} + {1'b0, y};
            e_res   = wide[W-1:0];
            e_carry = wide[W];
        end
        e_ovf = (tr > 64'sh7FFFFFFF) || (tr < -64'sh80000000);
        z = (e_res == '0);
        case (c[3:1])
            3'd0: begin base = 1'b0; e_ctag = "R6"; end
            3'd1: begin base = z; e_ctag = "R7"; end
            3'd2: begin base = (tr < 0); e_ctag = "R8"; end
            3'd3: begin base = (tr <= 0); e_ctag = "R8"; end
            3'd4: begin base = !e_carry; e_ctag = "R9"; end
            3'd5: begin base = !e_carry || z; e_ctag = "R9"; end
            3'd6: begin base = e_ovf; e_ctag = "R10"; end
            default: begin base = e_res[0]; e_ctag = "R7"; end
        endcase
        e_ct = base ^ c[0];
    endtask

    task automatic step(input logic v, input logic s, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic [3:0] c);
        op_valid = v; op_sub = s; a = x; b = y; cond = c;
        model(v, s, x, y, c);
        @(posedge clk);
        @(negedge clk);
        compare_all(v ? (s ? "R4" : "R3") : "R11");
    endtask

    logic [W-1:0] corners [5];

    initial begin
        corners[0] = '0;
        corners[1] = 32'd1;
        corners[2] = '1;
        corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'h8000_0000;

        op_valid = 1'b1; a = '1; b = '1; cond = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero even with an operation presented
        check("R1", "out_valid", longint'(out_valid), 0);
        check("R1", "res", longint'(res), 0);
        check("R1", "carry", longint'(carry), 0);
        check("R1", "ovf", longint'(ovf), 0);
        check("R1", "cond_true", longint'(cond_true), 0);
        op_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int s = 0; s < 2; s++)
                    for (int c = 0; c < 16; c++)
                        step(1'b1, s[0], corners[i], corners[j], c[3:0]);

        for (int n = 0; n < 3000; n++) begin
            // R11: idle cycles with changing inputs
            if (n % 7 == 3)
                step(1'b0, 1'($urandom), $urandom, $urandom, 4'($urandom));
            else
                step(1'b1, 1'($urandom), $urandom, $urandom, 4'($urandom));
        end

        // R2: valid drops after a final idle cycle
        step(1'b0, 1'b0, '0, '0, 4'h0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule